// File: doc/BRIEF.md
# Key-Protected Reset Control Registers

This block is the register front end of a chip reset controller. It offers three 32-bit registers on a single-cycle write/read port. The cause register shows which reset source fired most recently. The control register holds an unlock key and an active-low software-reset bit. The configuration register chooses hard or soft reset for the external pin, four watchdogs and the software reset. The reset sequencer that consumes the outputs lies outside this block.

The software-reset bit and the configuration register are guarded by a magic key. Software first writes the unlock value into the key field. That write does nothing else. Exactly one protected write may then follow. Any write to the control register or the configuration register closes the lock again, so every protected write needs its own unlock.

Reset events reach the block as one-cycle strobes, one per source. The cause register is then replaced by a one-hot word. When several strobes arrive in the same cycle, a fixed priority picks one.

Top module: `reset_ctl_regs`

## Requirements
- R1: After power-on reset (rst_ni low), the register at offset 0x0 reads 0x00000001, offset 0x4 reads 0x00010003, offset 0x8 reads 0, sw_rst_req_o is 0 and soft_sel_o is 0.
- R2: A write to offset 0x4 whose bits 15:0 equal 0x5A69 opens the lock. From the next cycle, bits 15:0 at 0x4 read 0x000C. That write does not change bit 16 and does not raise sw_rst_req_o.
- R3: While locked, a write to 0x4 with any other key value leaves the key field reading 0x0003. A 0 in bit 16 of such a write raises no request.
- R4: Any write to 0x4 or 0x8 that does not carry the unlock value closes the lock. A second protected write without a fresh unlock has no effect.
- R5: An unlocked write to 0x4 with bit 16 = 0 drives sw_rst_req_o high for exactly the one cycle after the write edge, and bit 16 reads 0 in that cycle. Bit 16 then reads 1 again. An unlocked write with bit 16 = 1 raises no request.
- R6: Offset 0x8 bits 5:0 select soft (1) or hard (0) reset for, in order: the external pin, watchdogs 0 to 3, and the software reset. They drive soft_sel_o. A write changes them only while unlocked, and bits 31:6 read 0.
- R7: A strobe on src_evt_i[k] replaces the cause register with a one-hot word. The set bit is 1 for k=0 (pin), 2 for k=1 (PLL controller), 8+(k-2) for k=2..5 (watchdogs 0-3) and 28 for k=6 (emulation).
- R8: When several strobes coincide, the lowest index wins; power-on (rst_ni) outranks them all.
- R9: Writes to 0x0 change nothing and do not close the lock, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | 4 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| src_evt_i | input | 7 | One-cycle reset event strobes per source |
| sw_rst_req_o | output | 1 | Software reset request pulse |
| soft_sel_o | output | 6 | Per-source soft-reset selects, 1 = soft |

## Verification
A lock flag that sticks open shows up at the key field on the next read. It also shows up as a request pulse or a configuration change after a write that should have been ignored, in the cycle right after that write. A cause register that loses its one-hot form, or a wrong priority, shows in the read of offset 0x0 one cycle after the strobe. A software-reset bit that fails to return to 1 shows as a request held for two cycles or more.

// File: rtl/reset_ctl_pkg.sv
package reset_ctl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned KEY_W    = 16;
  localparam int unsigned NUM_SRC  = 7;   // pin, pll, wd0..wd3, emu
  localparam int unsigned NUM_WD   = 4;
  localparam int unsigned CFG_W    = NUM_WD + 2;
  localparam int unsigned SWRST_BIT = 16;

  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5A69;
  localparam logic [KEY_W-1:0] KEY_OPEN   = 16'h000C;
  localparam logic [KEY_W-1:0] KEY_SHUT   = 16'h0003;

  localparam int unsigned OFF_CAUSE = 0;
  localparam int unsigned OFF_CTRL  = 4;
  localparam int unsigned OFF_CFG   = 8;

  localparam int unsigned POS_POR = 0;

  // cause-register bit for event source index
  function automatic int unsigned src_pos(int unsigned idx);
    if (idx == 0)                 return 1;
    else if (idx == 1)            return 2;
    else if (idx < 2 + NUM_WD)    return 8 + idx - 2;
    else                          return 28;
  endfunction
endpackage

// File: rtl/rcr_key_lock.sv
module rcr_key_lock
  import reset_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             cfg_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             unlocked_o,
  output logic [KEY_W-1:0] key_o
);
  logic unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              unlocked_q <= 1'b0;
    else if (ctrl_wr_i && key_i == KEY_UNLOCK) unlocked_q <= 1'b1;
    else if (ctrl_wr_i || cfg_wr_i)           unlocked_q <= 1'b0;
  end

  assign unlocked_o = unlocked_q;
  assign key_o      = unlocked_q ? KEY_OPEN : KEY_SHUT;
endmodule

// File: rtl/rcr_cause_capture.sv
module rcr_cause_capture
  import reset_ctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [DATA_W-1:0]  cause_o
);
  logic [DATA_W-1:0] cause_q, pick;

  // lowest index wins: scan from the top, later hits override
  always_comb begin
    pick = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--)
      if (evt_i[k]) pick = DATA_W'(1) << src_pos(k);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cause_q <= DATA_W'(1) << POS_POR;
    else if (|evt_i) cause_q <= pick;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rcr_swrst.sv
module rcr_swrst
  import reset_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             unlocked_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             bit_i,
  output logic             bit_o
);
  logic bit_q, fire;

  // an unlocking write never touches the bit
  assign fire = ctrl_wr_i && unlocked_i && key_i != KEY_UNLOCK && !bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= 1'b1;
    else         bit_q <= !fire;
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/reset_ctl_regs.sv
module reset_ctl_regs
  import reset_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_evt_i,
  output logic               sw_rst_req_o,
  output logic [CFG_W-1:0]   soft_sel_o
);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);

  logic              wr_ctrl, wr_cfg, unlocked, swrst_bit;
  logic [KEY_W-1:0]  key_rd;
  logic [DATA_W-1:0] cause_q;
  logic [CFG_W-1:0]  cfg_q;

  assign wr_ctrl = wr_en_i && addr_i == A_CTRL;
  assign wr_cfg  = wr_en_i && addr_i == A_CFG;

  rcr_key_lock u_lock (
    .clk_i, .rst_ni,
    .ctrl_wr_i  (wr_ctrl),
    .cfg_wr_i   (wr_cfg),
    .key_i      (wdata_i[KEY_W-1:0]),
    .unlocked_o (unlocked),
    .key_o      (key_rd)
  );

  rcr_swrst u_swrst (
    .clk_i, .rst_ni,
    .ctrl_wr_i  (wr_ctrl),
    .unlocked_i (unlocked),
    .key_i      (wdata_i[KEY_W-1:0]),
    .bit_i      (wdata_i[SWRST_BIT]),
    .bit_o      (swrst_bit)
  );

  rcr_cause_capture u_cause (
    .clk_i, .rst_ni,
    .evt_i   (src_evt_i),
    .cause_o (cause_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cfg_q <= '0;
    else if (wr_cfg && unlocked) cfg_q <= wdata_i[CFG_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CAUSE: rdata_o = cause_q;
      A_CTRL: begin
        rdata_o[KEY_W-1:0] = key_rd;
        rdata_o[SWRST_BIT] = swrst_bit;
      end
      A_CFG:   rdata_o[CFG_W-1:0] = cfg_q;
      default: rdata_o = '0;
    endcase
  end

  assign sw_rst_req_o = !swrst_bit;
  assign soft_sel_o   = cfg_q;
endmodule

// File: rtl/reset_ctl_regs_chk.sv
module reset_ctl_regs_chk
  import reset_ctl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_ctrl,
  input logic               wr_cfg,
  input logic               wr_en_i,
  input logic [3:0]         addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               unlocked,
  input logic [DATA_W-1:0]  cause_q,
  input logic [NUM_SRC-1:0] src_evt_i,
  input logic               sw_rst_req_o,
  input logic [CFG_W-1:0]   soft_sel_o
);
  AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cause_q) == 1); // R7
  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_req_o |=> !sw_rst_req_o); // R5
  AST_REQ_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_req_o |-> $past(unlocked && wr_ctrl)); // R3
  AST_RELOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_ctrl && wdata_i[KEY_W-1:0] != KEY_UNLOCK) || wr_cfg) |=> !unlocked); // R4
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(soft_sel_o)); // R6
  AST_PIN_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_evt_i[0] |=> cause_q == 32'h2); // R8
  AST_CAUSE_WR_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'h0 && src_evt_i == '0) |=> $stable(cause_q)); // R9
endmodule

bind reset_ctl_regs reset_ctl_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .unlocked(unlocked),
  .cause_q(cause_q), .src_evt_i(src_evt_i), .sw_rst_req_o(sw_rst_req_o),
  .soft_sel_o(soft_sel_o)
);

// File: tb/reset_ctl_regs_test.sv
`timescale 1ns/1ps
module reset_ctl_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [6:0]  src_evt_i = '0;
  logic        sw_rst_req_o;
  logic [5:0]  soft_sel_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  reset_ctl_regs uut (.*);

  function automatic int exp_pos(int k);
    case (k)
      0: return 1;
      1: return 2;
      6: return 28;
      default: return 6 + k;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
    #1;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic evt(logic [6:0] v);
    @(negedge clk_i); src_evt_i = v;
    @(negedge clk_i); src_evt_i = '0;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i); #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    rd(4'h0, d); check("R1 cause", d, 32'h1);
    rd(4'h4, d); check("R1 ctrl", d, 32'h0001_0003);
    rd(4'h8, d); check("R1 cfg", d, 32'h0);
    check("R1 req", {31'b0, sw_rst_req_o}, 32'h0);
    check("R1 soft", {26'b0, soft_sel_o}, 32'h0);

    // R7 each source alone
    for (int k = 0; k < 7; k++) begin
      evt(7'(1 << k));
      rd(4'h0, d); check("R7 single", d, 32'h1 << exp_pos(k));
    end
    // R8 every pair: lower index wins
    for (int a = 0; a < 7; a++)
      for (int b = a + 1; b < 7; b++) begin
        evt(7'((1 << a) | (1 << b)));
        rd(4'h0, d); check("R8 pair", d, 32'h1 << exp_pos(a));
      end
    evt(7'h7F);
    rd(4'h0, d); check("R8 all", d, 32'h2);

    // R9 cause write ignored, unmapped read 0, no relock
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R9 cause wr", d, 32'h2);
    rd(4'hC, d); check("R9 unmapped", d, 32'h0);
    wr(4'h4, 32'h0001_5A69);
    wr(4'h0, 32'h0);
    rd(4'h4, d); check("R9 still open", d, 32'h0001_000C);
    wr(4'h8, 32'h3F);
    rd(4'h8, d); check("R9 cfg after cause wr", d, 32'h3F);

    // R2 unlock only; bit16=0 in unlock write ignored
    wr(4'h4, 32'h0000_5A69);
    check("R2 no req", {31'b0, sw_rst_req_o}, 32'h0);
    rd(4'h4, d); check("R2 open", d, 32'h0001_000C);
    idle();
    check("R2 no req later", {31'b0, sw_rst_req_o}, 32'h0);

    // R5 pulse
    wr(4'h4, 32'h0000_0000);
    check("R5 req high", {31'b0, sw_rst_req_o}, 32'h1);
    rd(4'h4, d); check("R5 bit low", d, 32'h0000_0003);
    idle();
    check("R5 req low", {31'b0, sw_rst_req_o}, 32'h0);
    rd(4'h4, d); check("R5 bit back", d, 32'h0001_0003);
    wr(4'h4, 32'h0001_5A69);
    wr(4'h4, 32'h0001_1234);
    check("R5 bit1 no req", {31'b0, sw_rst_req_o}, 32'h0);

    // R3 invalid keys while locked
    foreach (d[i]) if (i < 6) begin
      logic [15:0] keys [6] = '{16'h5A68, 16'h5A6B, 16'h0000, 16'h000C, 16'hFFFF, 16'hA596};
      wr(4'h4, {16'h0000, keys[i]});
      check("R3 no req", {31'b0, sw_rst_req_o}, 32'h0);
      rd(4'h4, d); check("R3 locked", d, 32'h0001_0003);
    end

    // R4 relock after each protected write
    wr(4'h4, 32'h0001_5A69);
    wr(4'h8, 32'h01);
    rd(4'h4, d); check("R4 relocked", d, 32'h0001_0003);
    wr(4'h8, 32'h3E);
    rd(4'h8, d); check("R4 cfg held", d, 32'h01);
    check("R4 soft held", {26'b0, soft_sel_o}, 32'h01);
    wr(4'h4, 32'h0001_5A69);
    wr(4'h4, 32'h0001_0000);
    wr(4'h4, 32'h0000_0000);
    check("R4 no req", {31'b0, sw_rst_req_o}, 32'h0);

    // R6 config sweep with reserved bits set in the write
    for (int v = 0; v < 64; v++) begin
      wr(4'h4, 32'h0001_5A69);
      wr(4'h8, 32'hFFFF_FFC0 | 32'(v));
      rd(4'h8, d); check("R6 cfg rd", d, 32'(v));
      check("R6 soft", {26'b0, soft_sel_o}, 32'(v));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule